// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a programmable sum-of-products fabric. It has a programmable AND plane and a hard-wired OR plane. Each product term can take any array input in true form, in complemented form, or leave it out. Product terms are split into fixed blocks, one block per output. A single OR gate sums each block. Each output then passes through two programmable stages:

- An optional flip-flop stage, clocked on the rising edge of `clk`.
- A programmable inversion, so the output appears as the OR value or the NOR value.

The whole fuse map sits in one serial shift register. It is loaded through `cfg_en`, `cfg_din` and `cfg_clk` before normal use. The default parameters give 16 array inputs and 8 outputs, with 8 product terms per output (64 terms in all). A user makes the outputs active-low by programming the inversion bits.

Top module: `pal_array`

## Requirements
- R1: Product term t has two enable bits for each input i. Fuse bit t*2*N_IN+2*i enables the true literal of input i, and fuse bit t*2*N_IN+2*i+1 enables the complemented literal. A term is 1 exactly when at least one literal is enabled and every enabled literal is satisfied.
- R2: A product term with no literal enabled evaluates to 0, so it adds nothing to its output's sum.
- R3: A product term that enables both the true and the complemented literal of the same input evaluates to 0 for every input vector.
- R4: Output o is the OR of product terms o*PT_PER_OUT to o*PT_PER_OUT+PT_PER_OUT-1 only. No other term affects it.
- R5: The inversion bit of output o is fuse bit N_PT*2*N_IN+o. A value of 1 drives the complement of the selected sum on `dout[o]`, and a value of 0 drives the sum unchanged.
- R6: The register-select bit of output o is fuse bit N_PT*2*N_IN+N_OUT+o. When it is 0, `dout[o]` follows the inputs combinationally. When it is 1, the sum is captured on each rising `clk` edge, and `dout[o]` shows the captured value (after inversion) until the next edge.
- R7: A synchronous active-high `rst` clears the output flip-flops before inversion. After a reset edge, a registered output equals its inversion bit.
- R8: While `cfg_en` is high, each rising `cfg_clk` edge shifts `cfg_din` into the chain. After N_FUSE shifts, the first bit shifted in sits at fuse bit 0 and the last bit sits at fuse bit N_FUSE-1.
- R9: While `cfg_en` is high, every sum is forced to 0, so each output shows its inversion bit. Output flip-flops load 0 on each `clk` edge during configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output flip-flops |
| rst | input | 1 | Synchronous active-high reset of the output flip-flops |
| cfg_clk | input | 1 | Shift clock of the fuse chain |
| cfg_en | input | 1 | Shift enable of the fuse chain; forces outputs to their inactive level |
| cfg_din | input | 1 | Serial fuse data |
| din | input | N_IN (16) | Array inputs |
| dout | output | N_OUT (8) | Array outputs after register stage and inversion |

## Verification
The bench uses several input patterns, and each one separates a different fault:

- Maps of only empty terms and maps of only contradictory terms must hold every output at its inversion bit, whatever the inputs are. A wrong default for an empty AND, or a dropped literal, shows up here.
- Hand-built maps give each output one true-literal term, or one complement-literal term, on its own input. A one-hot and one-cold sweep over all 16 inputs then exposes any crossed OR grouping, any swapped literal encoding and any off-by-one in the shift order.
- Random sparse maps, in all-combinational, all-registered and mixed modes with random inversion, are driven with random vectors. Each output is compared against a bench sum-of-products both before and after the clock edge, which separates the register timing from the inversion.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Per-output control decoded from the tail of the fuse chain
    typedef struct packed {
        logic regd;    // 1: output taken from flip-flop
        logic invert;  // 1: complemented (NOR) output
    } out_ctl_t;

    // Position of the inversion bit of output o
    function automatic int inv_pos(input int n_pt, input int n_in, input int o);
        return n_pt * 2 * n_in + o;
    endfunction

    // Position of the register-select bit of output o
    function automatic int regsel_pos(input int n_pt, input int n_in, input int n_out, input int o);
        return n_pt * 2 * n_in + n_out + o;
    endfunction

endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
    parameter int LEN = 2064
) (
    input  logic           cfg_clk,
    input  logic           cfg_en,
    input  logic           cfg_din,
    output logic [LEN-1:0] fuse
);

    // R8: new bit enters at the top; first bit shifted ends at index 0
    always_ff @(posedge cfg_clk) begin
        if (cfg_en) begin
            fuse <= {cfg_din, fuse[LEN-1:1]};
        end
    end

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
    parameter int N_IN = 16,
    parameter int N_PT = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IN-1:0]        din,
    input  logic [N_PT*2*N_IN-1:0] lits,
    output logic [N_PT-1:0]        pt
);

    localparam int W = 2 * N_IN;

    for (genvar t = 0; t < N_PT; t++) begin : g_pt
        logic [N_IN-1:0] use_t;
        logic [N_IN-1:0] use_c;
        logic            any_lit;
        logic            all_met;

        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                use_t[i] = lits[t*W + 2*i];
                use_c[i] = lits[t*W + 2*i + 1];
            end
        end

        assign any_lit = (|use_t) | (|use_c);
        assign all_met = &((~use_t | din) & (~use_c | ~din));
        assign pt[t]   = any_lit & all_met;

        // R2: an unprogrammed term never contributes
        assert_empty_term_R2: assert property (@(posedge clk) disable iff (rst)
            ((use_t == '0) && (use_c == '0)) |-> !pt[t]);

        // R3: a literal and its complement together can never be satisfied
        assert_conflict_term_R3: assert property (@(posedge clk) disable iff (rst)
            ((use_t & use_c) != '0) |-> !pt[t]);
    end

endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
    import pal_pkg::*;
#(
    parameter int N_PT = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_en,
    input  logic [N_PT-1:0] pt,
    input  out_ctl_t        ctl,
    output logic            dout
);

    logic sum;
    logic q_r;
    logic sel;

    // R4, R9: fixed OR of this output's own terms, quiet during configuration
    assign sum = ~cfg_en & (|pt);

    // R6, R7: register stage sits before the inversion
    always_ff @(posedge clk) begin
        if (rst || cfg_en) begin
            q_r <= 1'b0;
        end else begin
            q_r <= sum;
        end
    end

    assign sel  = ctl.regd ? q_r : sum;
    assign dout = sel ^ ctl.invert;

    // R7: flop is clear right after a reset edge
    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !q_r);

    // R6: flop holds the sum seen at the previous edge
    assert_reg_capture_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> (q_r == $past(sum)));

    // R9: configuration leaves the flop cleared
    assert_cfg_clear_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> !q_r);

endmodule

// File: rtl/pal_array.sv
module pal_array
    import pal_pkg::*;
#(
    parameter int N_IN       = 16,
    parameter int N_OUT      = 8,
    parameter int PT_PER_OUT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_clk,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] dout
);

    localparam int N_PT    = N_OUT * PT_PER_OUT;
    localparam int PT_BITS = N_PT * 2 * N_IN;
    localparam int N_FUSE  = PT_BITS + 2 * N_OUT;

    logic [N_FUSE-1:0] fuse;
    logic [N_PT-1:0]   pt;

    pal_cfg_chain #(.LEN(N_FUSE)) u_chain (
        .cfg_clk (cfg_clk),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .fuse    (fuse)
    );

    pal_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .lits (fuse[PT_BITS-1:0]),
        .pt   (pt)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        out_ctl_t ctl;
        assign ctl.invert = fuse[inv_pos(N_PT, N_IN, o)];
        assign ctl.regd   = fuse[regsel_pos(N_PT, N_IN, N_OUT, o)];

        pal_out_cell #(.N_PT(PT_PER_OUT)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .cfg_en (cfg_en),
            .pt     (pt[o*PT_PER_OUT +: PT_PER_OUT]),
            .ctl    (ctl),
            .dout   (dout[o])
        );
    end

endmodule

// File: tb/pal_array_tb.sv
module pal_array_tb_top;

    localparam int NI    = 16;
    localparam int NO    = 8;
    localparam int PT    = 8;
    localparam int NPT   = NO * PT;
    localparam int PTB   = NPT * 2 * NI;
    localparam int NFUSE = PTB + 2 * NO;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_en = 1'b0;
    logic          cfg_din = 1'b0;
    logic [NI-1:0] din = '0;
    logic [NO-1:0] dout;

    logic [NFUSE-1:0] fuse_m;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pal_array dut_i (
        .clk     (clk),
        .rst     (rst),
        .cfg_clk (clk),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .din     (din),
        .dout    (dout)
    );

    function automatic logic [NO-1:0] pol_v();
        logic [NO-1:0] p;
        for (int o = 0; o < NO; o++) p[o] = fuse_m[PTB + o];
        return p;
    endfunction

    function automatic logic [NO-1:0] reg_v();
        logic [NO-1:0] r;
        for (int o = 0; o < NO; o++) r[o] = fuse_m[PTB + NO + o];
        return r;
    endfunction

    // Reference sum-of-products from the bench's own copy of the map
    function automatic logic [NO-1:0] model_sum(input logic [NI-1:0] x);
        logic [NO-1:0] s = '0;
        for (int o = 0; o < NO; o++) begin
            for (int t = 0; t < PT; t++) begin
                int  base = (o * PT + t) * 2 * NI;
                bit  any_l = 0;
                bit  ok = 1;
                for (int i = 0; i < NI; i++) begin
                    if (fuse_m[base + 2*i])     begin any_l = 1; if (!x[i]) ok = 0; end
                    if (fuse_m[base + 2*i + 1]) begin any_l = 1; if (x[i])  ok = 0; end
                end
                if (any_l && ok) s[o] = 1'b1;
            end
        end
        return s;
    endfunction

    task automatic chk(input string req, input logic [NO-1:0] mask, input logic [NO-1:0] exp);
        for (int o = 0; o < NO; o++) begin
            if (mask[o]) begin
                n_cmp++;
                if (dout[o] !== exp[o]) begin
                    n_bad++;
                    $display("FAIL %s out%0d din=%h actual=%b expected=%b", req, o, din, dout[o], exp[o]);
                end
            end
        end
    endtask

    // R8: serial load, bit 0 first; R9 checked with cfg_en still high
    task automatic load_map();
        for (int k = 0; k < NFUSE; k++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = fuse_m[k];
        end
        @(negedge clk);
        chk("R9", '1, pol_v());
        cfg_en = 1'b0;
    endtask

    // One vector: combinational outputs before the edge, registered after it
    task automatic apply(input logic [NI-1:0] v, input string req_c, input string req_r);
        logic [NO-1:0] e;
        din = v;
        #1;
        e = pol_v() ^ model_sum(v);
        chk(req_c, ~reg_v(), e);
        @(posedge clk);
        #1;
        chk(req_r, reg_v(), e);
        chk(req_c, ~reg_v(), e);
        @(negedge clk);
    endtask

    task automatic rand_map(input logic [NO-1:0] regsel);
        fuse_m = '0;
        for (int t = 0; t < NPT; t++) begin
            int k = $urandom % 4;
            for (int j = 0; j < k; j++) begin
                int i = $urandom % NI;
                int c = $urandom % 2;
                fuse_m[t*2*NI + 2*i + c] = 1'b1;
            end
        end
        for (int o = 0; o < NO; o++) begin
            fuse_m[PTB + o]      = 1'($urandom % 2);
            fuse_m[PTB + NO + o] = regsel[o];
        end
    endtask

    task automatic set_ctl(input logic [NO-1:0] pol, input logic [NO-1:0] regsel);
        for (int o = 0; o < NO; o++) begin
            fuse_m[PTB + o]      = pol[o];
            fuse_m[PTB + NO + o] = regsel[o];
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state of registered outputs equals inversion bit
        fuse_m = '0;
        set_ctl(8'h3C, 8'hFF);
        for (int t = 0; t < NPT; t++) fuse_m[t*2*NI + 2*(t % NI)] = 1'b1;
        load_map();
        apply('1, "R1", "R6");
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R7", '1, 8'h3C);
        @(negedge clk);
        rst = 1'b0;

        // R2: empty terms only
        fuse_m = '0;
        set_ctl(8'hA5, 8'h0F);
        load_map();
        for (int n = 0; n < 24; n++) apply(NI'($urandom), "R2", "R2");

        // R3: contradictory terms only
        fuse_m = '0;
        set_ctl(8'h5A, 8'hF0);
        for (int t = 0; t < NPT; t++) begin
            fuse_m[t*2*NI + 2*(t % NI)]     = 1'b1;
            fuse_m[t*2*NI + 2*(t % NI) + 1] = 1'b1;
            fuse_m[t*2*NI + 2*((t+3) % NI)] = 1'b1;
        end
        load_map();
        for (int n = 0; n < 24; n++) apply(NI'($urandom), "R3", "R3");
        apply('1, "R3", "R3");
        apply('0, "R3", "R3");

        // R4, R1: output o uses true literal of input 2o in one of its own terms
        fuse_m = '0;
        set_ctl(8'h00, 8'h00);
        for (int o = 0; o < NO; o++) fuse_m[(o*PT + o)*2*NI + 2*(2*o)] = 1'b1;
        load_map();
        for (int i = 0; i < NI; i++) apply(NI'(1) << i, "R4", "R4");

        // R4, R1: complement literal of input 2o+1, one-cold sweep
        fuse_m = '0;
        set_ctl(8'h00, 8'h00);
        for (int o = 0; o < NO; o++) fuse_m[(o*PT + (PT-1-o))*2*NI + 2*(2*o+1) + 1] = 1'b1;
        load_map();
        for (int i = 0; i < NI; i++) apply(~(NI'(1) << i), "R1", "R1");

        // R5, R6, R8: random maps in three register modes
        for (int m = 0; m < 4; m++) begin
            logic [NO-1:0] rs;
            rs = (m == 0) ? 8'h00 : (m == 1) ? 8'hFF : NO'($urandom);
            rand_map(rs);
            load_map();
            for (int n = 0; n < 500; n++) apply(NI'($urandom), "R5", "R6");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule